// File: doc/BRIEF.md
# Priority Address Window Translator

This block turns local-bus addresses into PCI bus addresses. It holds three programmable windows. Each window has a base register and a map register. The base register gives the local address, the size and an enable bit. The map register gives the PCI-side base, the cycle type and a low-address-enable option. For each request the block searches the windows in ascending index order, and the lowest-numbered enabled window that contains the address wins. The block returns the translated address, the cycle type, the winning window and a hit or miss flag. The result is registered, so it appears one cycle after the request is accepted, and it uses a valid/ready handshake on both sides.

Windows may overlap. Because the search order is fixed, software can grow window 0 until it covers window 1. Window 1 is then hidden and can be reprogrammed to reach configuration space with no decode conflict. For configuration cycles the block forms the low address bits for type 0 or type 1 accesses. A miss sets a sticky error flag, and a dedicated register write clears it.

Top module: `addr_window_xlate`

## Requirements
- R1: After reset every window is disabled, `rsp_valid` is 0, `miss_sticky` is 0 and `req_ready` is 1. Any request made before programming misses.
- R2: A write with `reg_wr_en` = 1 targets window `reg_wr_addr[2:1]`. `reg_wr_addr[0]` = 0 selects the base register and 1 selects the map register.
  - Base register format: bits 31:20 hold the local base, bits 4:1 hold the size code (size = 1 MB << code, codes above 11 act as 11), and bit 0 is the enable.
  - Map register format: bits 31:20 hold the PCI base, bits 2:1 hold the type, and bit 0 is the low-address enable.
- R3: A window matches when it is enabled and the address agrees with its base in every bit at or above log2(size). Base bits below the size are ignored, so an address one past the window end does not match.
- R4: When several enabled windows match, the lowest-numbered one is used.
- R5: A disabled window never matches, whatever its base and size.
- R6: The translated address takes the map register's PCI base bits at and above log2(size), and the request address bits below it.
- R7: The type code selects the cycle type: 0 is memory, 1 is prefetchable memory, 2 is I/O and 3 is configuration. `rsp_cycle` carries the same code. A hit in window 2 always reports I/O (2), whatever its map type.
- R8: For a configuration hit with the low-address enable clear, `rsp_addr[1:0]` is 00 and `rsp_cfg_t1` is 0. This is type 0, and the device-select bits above the window come from the map register. With the low-address enable set, bits 1:0 pass through from the request and `rsp_cfg_t1` is 1.
- R9: When no enabled window matches, the response has `rsp_hit` = 0 and `rsp_miss` = 1, and `miss_sticky` is set. A write to `reg_wr_addr` = 6 clears `miss_sticky`. If a miss is captured on the same edge as a clear, the flag is set.
- R10: A register write takes effect on the next clock edge. A request accepted on the same edge is decoded with the old register values.
- R11: A request is accepted when `req_valid` and `req_ready` are both 1. Its response appears one cycle later. `req_ready` = !`rsp_valid` || `rsp_ready`, and a stalled response holds all of its fields stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_addr | input | 3 | Register select: {window, map/base} or 6 = clear error |
| reg_wr_data | input | 32 | Register write data |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted this cycle when high with valid |
| req_addr | input | 32 | Local-bus address |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Consumer accepts response |
| rsp_addr | output | 32 | Translated PCI address |
| rsp_cycle | output | 2 | Cycle type code |
| rsp_win | output | 2 | Index of winning window |
| rsp_hit | output | 1 | A window matched |
| rsp_miss | output | 1 | No window matched |
| rsp_cfg_t1 | output | 1 | Configuration cycle with pass-through low bits (type 1) |
| miss_sticky | output | 1 | Sticky miss flag |

## Verification
The bench grows window 0 over window 1 to check priority, because a reversed search would return the prefetchable translation instead. It probes the last byte of a window and the first byte past it, since an off-by-one mask would let the next region alias in. It also sets base bits below the window size, which a design that compares the full base would reject. It places a request on the same edge as a write that enables its window, and on the same edge as a clear of the error flag. A design that bypasses the new register value would hit where it should miss, and a design where the clear beats the set would lose the error. Stalled responses must not change, and window 2 must report I/O even when its map says memory.

// File: rtl/axl_pkg.sv
package axl_pkg;
    localparam int ADDR_W    = 32;
    localparam int NUM_WIN   = 3;
    localparam int MIN_SHIFT = 20;
    localparam int MAX_CODE  = ADDR_W - 1 - MIN_SHIFT;
    localparam int IO_WIN    = 2;

    typedef enum logic [1:0] {
        CYC_MEM  = 2'd0,
        CYC_PREF = 2'd1,
        CYC_IO   = 2'd2,
        CYC_CFG  = 2'd3
    } cycle_e;

    localparam logic [2:0] CLR_ADDR = 3'd6;
endpackage

// File: rtl/axl_regs.sv
// Window register file. Holds a base and a map register for each window.
// Assumes reg_wr_addr[2:1] selects the window and reg_wr_addr[0] selects map(1) or base(0).
// Writes to absent windows are dropped.
module axl_regs
    import axl_pkg::*;
#(
    parameter int NW = NUM_WIN,
    parameter int AW = ADDR_W
)(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [2:0]           wr_addr,
    input  logic [AW-1:0]        wr_data,
    output logic [NW-1:0][AW-1:0] base_q,
    output logic [NW-1:0][AW-1:0] map_q
);
    for (genvar i = 0; i < NW; i++) begin : g_win
        // Capture base/map writes for window i; reset leaves it disabled.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                base_q[i] <= '0;
                map_q[i]  <= '0;
            end else if (wr_en && (wr_addr[2:1] == i[1:0])) begin
                if (wr_addr[0]) map_q[i]  <= wr_data;
                else            base_q[i] <= wr_data;
            end
        end
    end
endmodule

// File: rtl/axl_match.sv
// One window's decoder: range test, address translation and cycle type.
// Assumes base bit 0 = enable, base[4:1] = log2(size/1MB), map[2:1] = type, map[0] = low enable.
// FORCE_IO makes the window report I/O whatever the map type says.
module axl_match
    import axl_pkg::*;
#(
    parameter int AW       = ADDR_W,
    parameter int MS       = MIN_SHIFT,
    parameter bit FORCE_IO = 1'b0
)(
    input  logic [AW-1:0] addr,
    input  logic [AW-1:0] base,
    input  logic [AW-1:0] map,
    output logic          hit,
    output logic [AW-1:0] xaddr,
    output logic [1:0]    cycle,
    output logic          cfg_t1
);
    localparam int MC = AW - 1 - MS;

    logic [3:0]    code_eff;
    logic [AW-1:0] mask;
    logic          is_cfg;

    // Clamp the size code and build the mask of the bits at and above the size.
    always_comb begin
        code_eff = (int'(base[4:1]) > MC) ? 4'(MC) : base[4:1];
        mask     = {AW{1'b1}} << (MS + int'(code_eff));
    end

    // Range test against the enabled base.
    always_comb hit = base[0] && (((addr ^ base) & mask) == '0);

    // Pick the cycle type; the I/O-only window overrides the map.
    always_comb cycle = FORCE_IO ? 2'(CYC_IO) : map[2:1];

    // Build the translated address and the type 0/1 low bits.
    always_comb begin
        is_cfg = (cycle == 2'(CYC_CFG));
        cfg_t1 = is_cfg && map[0];
        xaddr  = (map & mask) | (addr & ~mask);
        if (is_cfg && !map[0]) xaddr[1:0] = 2'b00;
    end
endmodule

// File: rtl/axl_pick.sv
// Fixed-priority selector: returns the lowest-index asserted hit.
// Assumes at most 4 windows (2-bit index).
module axl_pick #(
    parameter int NW = 3
)(
    input  logic [NW-1:0] hits,
    output logic          found,
    output logic [1:0]    idx
);
    // Scan from the top so the lowest index ends up winning.
    always_comb begin
        found = 1'b0;
        idx   = 2'd0;
        for (int i = NW - 1; i >= 0; i--) begin
            if (hits[i]) begin
                found = 1'b1;
                idx   = 2'(i);
            end
        end
    end
endmodule

// File: rtl/addr_window_xlate.sv
// Priority address window translator (top).
// Decodes each accepted request against the windows in ascending order and registers the
// result (1-cycle latency). A miss sets a sticky flag; a write to address 6 clears it.
// Assumes the consumer holds rsp_ready low to stall; the response then stays stable.
module addr_window_xlate
    import axl_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr_en,
    input  logic [2:0]  reg_wr_addr,
    input  logic [31:0] reg_wr_data,
    input  logic        req_valid,
    output logic        req_ready,
    input  logic [31:0] req_addr,
    output logic        rsp_valid,
    input  logic        rsp_ready,
    output logic [31:0] rsp_addr,
    output logic [1:0]  rsp_cycle,
    output logic [1:0]  rsp_win,
    output logic        rsp_hit,
    output logic        rsp_miss,
    output logic        rsp_cfg_t1,
    output logic        miss_sticky
);
    localparam int NW = NUM_WIN;
    localparam int AW = ADDR_W;

    logic [NW-1:0][AW-1:0] base_q, map_q;
    logic [NW-1:0]         hits, t1s;
    logic [NW-1:0][AW-1:0] xaddrs;
    logic [NW-1:0][1:0]    cycles;
    logic                  found;
    logic [1:0]            sel;
    logic                  accept;
    logic                  clr_wr;

    axl_regs #(.NW(NW), .AW(AW)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(reg_wr_en), .wr_addr(reg_wr_addr),
        .wr_data(reg_wr_data), .base_q(base_q), .map_q(map_q)
    );

    for (genvar i = 0; i < NW; i++) begin : g_dec
        axl_match #(.AW(AW), .MS(MIN_SHIFT), .FORCE_IO(i == IO_WIN)) u_match (
            .addr(req_addr), .base(base_q[i]), .map(map_q[i]),
            .hit(hits[i]), .xaddr(xaddrs[i]), .cycle(cycles[i]), .cfg_t1(t1s[i])
        );
    end

    axl_pick #(.NW(NW)) u_pick (.hits(hits), .found(found), .idx(sel));

    // Handshake: accept when the output slot is empty or being drained.
    always_comb begin
        req_ready = !rsp_valid || rsp_ready;
        accept    = req_valid && req_ready;
        clr_wr    = reg_wr_en && (reg_wr_addr == CLR_ADDR);
    end

    // Response register: load on accept, drop on drain, hold while stalled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid  <= 1'b0;
            rsp_addr   <= '0;
            rsp_cycle  <= '0;
            rsp_win    <= '0;
            rsp_hit    <= 1'b0;
            rsp_miss   <= 1'b0;
            rsp_cfg_t1 <= 1'b0;
        end else if (accept) begin
            rsp_valid  <= 1'b1;
            rsp_hit    <= found;
            rsp_miss   <= !found;
            rsp_win    <= sel;
            rsp_addr   <= found ? xaddrs[sel] : '0;
            rsp_cycle  <= found ? cycles[sel] : '0;
            rsp_cfg_t1 <= found && t1s[sel];
        end else if (rsp_ready) begin
            rsp_valid  <= 1'b0;
        end
    end

    // Sticky miss flag: set on a captured miss (set wins), cleared by a write to address 6.
    always_ff @(posedge clk) begin
        if (!rst_n)                 miss_sticky <= 1'b0;
        else if (accept && !found)  miss_sticky <= 1'b1;
        else if (clr_wr)            miss_sticky <= 1'b0;
    end
endmodule

// File: rtl/addr_window_xlate_chk.sv
// Protocol and decode checks for addr_window_xlate, attached with bind.
module addr_window_xlate_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        reg_wr_en,
    input logic [2:0]  reg_wr_addr,
    input logic        req_valid,
    input logic        req_ready,
    input logic        rsp_valid,
    input logic        rsp_ready,
    input logic [31:0] rsp_addr,
    input logic [1:0]  rsp_cycle,
    input logic [1:0]  rsp_win,
    input logic        rsp_hit,
    input logic        rsp_miss,
    input logic        rsp_cfg_t1,
    input logic        miss_sticky
);
    // R11
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_addr) && $stable(rsp_cycle)
                                       && $stable(rsp_win) && $stable(rsp_hit)));
    // R11
    ready_rule_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_ready) |-> !req_ready);
    // R9
    hit_xor_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_hit != rsp_miss));
    // R9
    miss_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_miss && $rose(rsp_valid)) |-> miss_sticky);
    // R9
    flag_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (miss_sticky && !(reg_wr_en && reg_wr_addr == 3'd6)) |=> miss_sticky);
    // R7
    io_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_hit && rsp_win == 2'd2) |-> (rsp_cycle == 2'd2));
    // R8
    type0_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_hit && rsp_cycle == 2'd3 && !rsp_cfg_t1) |-> (rsp_addr[1:0] == 2'b00));
    // R8
    t1_only_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_cfg_t1) |-> (rsp_hit && rsp_cycle == 2'd3));
    // R1
    reset_idle_chk: assert property (@(posedge clk)
        !rst_n |=> (!rsp_valid && !miss_sticky));
endmodule

bind addr_window_xlate addr_window_xlate_chk u_chk (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_wr_addr(reg_wr_addr),
    .req_valid(req_valid), .req_ready(req_ready), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_addr(rsp_addr), .rsp_cycle(rsp_cycle), .rsp_win(rsp_win),
    .rsp_hit(rsp_hit), .rsp_miss(rsp_miss), .rsp_cfg_t1(rsp_cfg_t1), .miss_sticky(miss_sticky)
);

// File: tb/addr_window_xlate_test.sv
module addr_window_xlate_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic [2:0]  reg_wr_addr = '0;
    logic [31:0] reg_wr_data = '0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_addr = '0;
    logic        rsp_valid;
    logic        rsp_ready = 1'b1;
    logic [31:0] rsp_addr;
    logic [1:0]  rsp_cycle;
    logic [1:0]  rsp_win;
    logic        rsp_hit, rsp_miss, rsp_cfg_t1, miss_sticky;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    addr_window_xlate uut (
        .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_wr_addr(reg_wr_addr),
        .reg_wr_data(reg_wr_data), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
        .rsp_addr(rsp_addr), .rsp_cycle(rsp_cycle), .rsp_win(rsp_win), .rsp_hit(rsp_hit),
        .rsp_miss(rsp_miss), .rsp_cfg_t1(rsp_cfg_t1), .miss_sticky(miss_sticky)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Register write alone; inputs change on the falling edge.
    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_wr_addr = a; reg_wr_data = d;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    // Optional write and one request on the same edge; response sampled a half cycle later.
    task automatic xfer(input bit do_wr, input logic [2:0] a, input logic [31:0] d,
                        input logic [31:0] ra);
        @(negedge clk);
        reg_wr_en = do_wr; reg_wr_addr = a; reg_wr_data = d;
        req_valid = 1'b1; req_addr = ra;
        @(negedge clk);
        reg_wr_en = 1'b0; req_valid = 1'b0;
    endtask

    task automatic expect_hit(input string tag, input logic [31:0] ra, input logic [1:0] w,
                              input logic [31:0] pa, input logic [1:0] cy, input logic t1);
        xfer(1'b0, 3'd0, 32'd0, ra);
        check({tag, " valid"}, 32'(rsp_valid), 32'd1);
        check({tag, " hit"},   32'(rsp_hit),   32'd1);
        check({tag, " win"},   32'(rsp_win),   32'(w));
        check({tag, " addr"},  rsp_addr,       pa);
        check({tag, " cycle"}, 32'(rsp_cycle), 32'(cy));
        check({tag, " t1"},    32'(rsp_cfg_t1), 32'(t1));
    endtask

    task automatic expect_miss(input string tag, input logic [31:0] ra);
        xfer(1'b0, 3'd0, 32'd0, ra);
        check({tag, " valid"}, 32'(rsp_valid), 32'd1);
        check({tag, " miss"},  32'(rsp_miss),  32'd1);
        check({tag, " hit"},   32'(rsp_hit),   32'd0);
        check({tag, " sticky"}, 32'(miss_sticky), 32'd1);
    endtask

    task automatic t_reset;  // R1
        @(negedge clk);
        check("R1 rsp_valid", 32'(rsp_valid), 32'd0);
        check("R1 sticky",    32'(miss_sticky), 32'd0);
        check("R1 req_ready", 32'(req_ready), 32'd1);
        expect_miss("R1 unprogrammed", 32'h4000_0000);
        wr(3'd6, 32'd0);
        check("R9 clear", 32'(miss_sticky), 32'd0);
    endtask

    task automatic t_program;  // R2 R6 R7
        wr(3'd0, 32'h4000_0011); wr(3'd1, 32'h0000_0000);
        wr(3'd2, 32'h5000_0011); wr(3'd3, 32'h1000_0002);
        wr(3'd4, 32'h6000_0009); wr(3'd5, 32'h0000_0004);
        expect_hit("R2 R6 win0 mem",  32'h4123_4567, 2'd0, 32'h0123_4567, 2'd0, 1'b0);
        expect_hit("R6 R7 win1 pref", 32'h5ABC_DEF0, 2'd1, 32'h1ABC_DEF0, 2'd1, 1'b0);
        expect_hit("R6 R7 win2 io",   32'h6012_3456, 2'd2, 32'h0012_3456, 2'd2, 1'b0);
    endtask

    task automatic t_bounds;  // R3
        expect_hit("R3 last byte", 32'h4FFF_FFFF, 2'd0, 32'h0FFF_FFFF, 2'd0, 1'b0);
        expect_hit("R3 next window", 32'h5000_0000, 2'd1, 32'h1000_0000, 2'd1, 1'b0);
        expect_miss("R3 past end", 32'h6100_0000);
        wr(3'd6, 32'd0);
        wr(3'd4, 32'h6050_0009);
        expect_hit("R3 low base bits ignored", 32'h6000_0004, 2'd2, 32'h0000_0004, 2'd2, 1'b0);
    endtask

    task automatic t_io_only;  // R7
        wr(3'd5, 32'h0000_0000);
        expect_hit("R7 win2 forced io", 32'h6000_0010, 2'd2, 32'h0000_0010, 2'd2, 1'b0);
    endtask

    task automatic t_priority;  // R4
        wr(3'd0, 32'h4000_0013);
        expect_hit("R4 win0 hides win1", 32'h5000_0100, 2'd0, 32'h1000_0100, 2'd0, 1'b0);
    endtask

    task automatic t_cfg;  // R8
        wr(3'd2, 32'h6100_0009); wr(3'd3, 32'h0800_0006);
        expect_hit("R8 type0", 32'h6100_0813, 2'd1, 32'h0800_0810, 2'd3, 1'b0);
        wr(3'd3, 32'h0000_0007);
        expect_hit("R8 type1", 32'h6101_2B05, 2'd1, 32'h0001_2B05, 2'd3, 1'b1);
    endtask

    task automatic t_disable;  // R5
        wr(3'd0, 32'h4000_0012);
        expect_miss("R5 disabled win0", 32'h4000_0040);
        expect_miss("R5 disabled win0 upper", 32'h5000_0000);
        expect_hit("R9 sticky holds on hit", 32'h6000_0020, 2'd2, 32'h0000_0020, 2'd2, 1'b0);
        check("R9 sticky after hit", 32'(miss_sticky), 32'd1);
        wr(3'd6, 32'd0);
        check("R9 cleared", 32'(miss_sticky), 32'd0);
    endtask

    task automatic t_old_value;  // R10
        xfer(1'b1, 3'd0, 32'h4000_0011, 32'h4000_0040);
        check("R10 old regs used", 32'(rsp_miss), 32'd1);
        expect_hit("R10 new regs next", 32'h4000_0040, 2'd0, 32'h0000_0040, 2'd0, 1'b0);
        wr(3'd6, 32'd0);
    endtask

    task automatic t_set_wins;  // R9
        xfer(1'b1, 3'd6, 32'd0, 32'h7000_0000);
        check("R9 miss beats clear", 32'(miss_sticky), 32'd1);
        wr(3'd6, 32'd0);
        check("R9 clear after", 32'(miss_sticky), 32'd0);
    endtask

    task automatic t_stall;  // R11
        @(negedge clk);
        rsp_ready = 1'b0; req_valid = 1'b1; req_addr = 32'h4000_0100;
        @(negedge clk);
        req_addr = 32'h6000_0200;
        check("R11 first valid", 32'(rsp_valid), 32'd1);
        check("R11 ready low", 32'(req_ready), 32'd0);
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            check("R11 held addr", rsp_addr, 32'h0000_0100);
            check("R11 held win", 32'(rsp_win), 32'd0);
        end
        rsp_ready = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        check("R11 second valid", 32'(rsp_valid), 32'd1);
        check("R11 second addr", rsp_addr, 32'h0000_0200);
        check("R11 second win", 32'(rsp_win), 32'd2);
        @(negedge clk);
        check("R11 drained", 32'(rsp_valid), 32'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_program();
        t_bounds();
        t_io_only();
        t_priority();
        t_cfg();
        t_disable();
        t_old_value();
        t_set_wins();
        t_stall();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule